// File: doc/BRIEF.md
# Table-Driven Trigger Item Combiner

This block turns a vector of decoded detector hit bits into a set of programmable trigger items. The input vector is cut into equal groups, and each group is used as the address of its own lookup table. Every table entry holds one bit per trigger item, so each item receives one contribution from each group.

For every item, each contribution is either enabled or masked out by a per-item mask. The enabled contributions are then reduced by a per-item choice of AND or OR. The item vector is registered once per bunch clock, one cycle after the hit vector is sampled.

Tables, masks and function selects are loaded through a single-cycle register write port. That port carries a target selector, a group index, a table address, a 32-bit lane index and a data word. After reset all configuration is cleared and every item reads 0.

Top module: `trig_item_combiner`

## Requirements
- R1: After reset, and until the first configuration write takes effect, `item_out` is all zeros; reset clears every table entry, every mask and every function select.
- R2: Group g of the input is `trig_in[8g+7:8g]` (default width 8), and it addresses table g only; item i's contribution from group g is bit i of that table entry.
- R3: A masked-out contribution is neutral: it counts as 1 under AND and 0 under OR. An item whose mask bits are clear in every group outputs 0 whatever its function select.
- R4: Function select bit i = 1 makes item i the AND of its enabled contributions; bit i = 0 makes it their OR.
- R5: `item_out` reflects the `trig_in` value sampled at the previous rising clock edge, with exactly one cycle of latency.
- R6: On a write, `wr_sel` = 0 loads table `wr_grp` at `wr_addr`, `wr_sel` = 1 loads the mask of group `wr_grp`, `wr_sel` = 2 loads the function selects, and `wr_sel` = 3 is ignored. `wr_lane` = l targets items 32l to 32l+31, with bit 0 of `wr_data` going to item 32l. Configuration changes only on a write.
- R7: A write does not change the `item_out` value registered on the same edge; the new contents first show on the output one edge later.
- R8: Each item's mask bits and function select act on that item alone; items with different settings evaluate independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | GROUPS*GROUP_W | Decoded hit bits, one group per table |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 table, 1 mask, 2 function, 3 none |
| wr_grp | input | clog2(GROUPS) | Table or mask group index |
| wr_addr | input | GROUP_W | Table entry address |
| wr_lane | input | LANE_W | 32-item lane index |
| wr_data | input | 32 | Write data, bit 0 to lowest item of the lane |
| item_out | output | N_ITEMS | Registered trigger items |

## Verification
A corrupted table entry shows only when its group presents that address, so the bench sweeps hit patterns across all four groups and checks the full item vector one edge after each one. A wrong mask or function bit affects one item for every input, so it appears on the first vector that sets that item's contributions unequal. A write that leaks into the same-edge output, or fails to land, is caught within two edges by the dedicated write-timing test.

// File: rtl/trig_item_combiner.sv
module trig_item_combiner #(
  parameter int N_ITEMS   = 128,
  parameter int GROUPS    = 4,
  parameter int GROUP_W   = 8,
  parameter int LANE_BITS = 32
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [GROUPS*GROUP_W-1:0]              trig_in,
  input  logic                                   wr_en,
  input  logic [1:0]                             wr_sel,
  input  logic [(GROUPS > 1 ? $clog2(GROUPS) : 1)-1:0] wr_grp,
  input  logic [GROUP_W-1:0]                     wr_addr,
  input  logic [((N_ITEMS/LANE_BITS) > 1 ? $clog2(N_ITEMS/LANE_BITS) : 1)-1:0] wr_lane,
  input  logic [LANE_BITS-1:0]                   wr_data,
  output logic [N_ITEMS-1:0]                     item_out
);
  localparam int DEPTH   = 1 << GROUP_W;
  localparam int LANES   = N_ITEMS / LANE_BITS;
  localparam int GRP_W   = GROUPS > 1 ? $clog2(GROUPS) : 1;
  localparam int ENTRIES = GROUPS * DEPTH;

  logic [N_ITEMS-1:0] tbl    [ENTRIES];
  logic [N_ITEMS-1:0] mask_q [GROUPS];
  logic [N_ITEMS-1:0] func_q;
  logic [N_ITEMS-1:0] hit    [GROUPS];
  logic [N_ITEMS-1:0] and_v, or_v, any_v, nxt;

  logic grp_ok, lane_ok;
  int   lane_off;
  assign grp_ok   = 32'(wr_grp) < GROUPS;
  assign lane_ok  = 32'(wr_lane) < LANES;
  assign lane_off = 32'(wr_lane) * LANE_BITS;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) tbl[e] <= '0;
      for (int g = 0; g < GROUPS; g++) mask_q[g] <= '0;
      func_q <= '0;
    end else if (wr_en && lane_ok) begin
      case (wr_sel)
        2'd0: if (grp_ok) tbl[{wr_grp, wr_addr}][lane_off +: LANE_BITS] <= wr_data;
        2'd1: if (grp_ok) mask_q[wr_grp][lane_off +: LANE_BITS] <= wr_data;
        2'd2: func_q[lane_off +: LANE_BITS] <= wr_data;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_rd
    assign hit[g] = tbl[{GRP_W'(g), trig_in[g*GROUP_W +: GROUP_W]}];
  end

  always_comb begin
    and_v = '1;
    or_v  = '0;
    any_v = '0;
    for (int g = 0; g < GROUPS; g++) begin
      and_v = and_v & (hit[g] | ~mask_q[g]);
      or_v  = or_v  | (hit[g] & mask_q[g]);
      any_v = any_v | mask_q[g];
    end
    nxt = (func_q & and_v & any_v) | (~func_q & or_v);
  end

  always_ff @(posedge clk) begin
    if (rst) item_out <= '0;
    else     item_out <= nxt;
  end
endmodule

module trig_item_combiner_chk #(
  parameter int N_ITEMS = 128,
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [GROUPS*GROUP_W-1:0] trig_in,
  input logic                      wr_en,
  input logic [N_ITEMS-1:0]        item_out,
  input logic [N_ITEMS-1:0]        mask_q [GROUPS],
  input logic [N_ITEMS-1:0]        func_q
);
  logic [N_ITEMS-1:0] none_mask;
  always_comb begin
    none_mask = '1;
    for (int g = 0; g < GROUPS; g++) none_mask = none_mask & ~mask_q[g];
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> item_out == '0);

  assert_unmasked_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (item_out & $past(none_mask)) == '0);

  assert_config_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(func_q) && $stable(none_mask)));

  assert_write_same_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(trig_in)) |=> $stable(item_out));
endmodule

bind trig_item_combiner trig_item_combiner_chk #(
  .N_ITEMS(N_ITEMS), .GROUPS(GROUPS), .GROUP_W(GROUP_W)
) u_chk (
  .clk(clk), .rst(rst), .trig_in(trig_in), .wr_en(wr_en),
  .item_out(item_out), .mask_q(mask_q), .func_q(func_q)
);

// File: tb/trig_item_combiner_test.sv
module trig_item_combiner_test;
  localparam int NI = 32;
  localparam int NG = 4;
  localparam int GW = 8;

  logic          clk = 0;
  logic          rst = 1;
  logic [31:0]   trig_in = '0;
  logic          wr_en = 0;
  logic [1:0]    wr_sel = '0;
  logic [1:0]    wr_grp = '0;
  logic [7:0]    wr_addr = '0;
  logic [0:0]    wr_lane = '0;
  logic [31:0]   wr_data = '0;
  logic [NI-1:0] item_out;

  trig_item_combiner #(.N_ITEMS(NI), .GROUPS(NG), .GROUP_W(GW)) uut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_grp(wr_grp), .wr_addr(wr_addr), .wr_lane(wr_lane), .wr_data(wr_data),
    .item_out(item_out));

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [NI-1:0] r_tbl [NG][256];
  logic [NI-1:0] r_mask [NG];
  logic [NI-1:0] r_func;

  localparam logic [31:0] VEC [12] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0102_0304, 32'h8040_2010,
    32'hA55A_C33C, 32'h00FF_00FF, 32'h1234_5678, 32'hDEAD_BEEF,
    32'h7F00_007F, 32'h0F0F_F0F0, 32'h0000_0001, 32'h8000_0000};

  function automatic logic [NI-1:0] model(input logic [31:0] t);
    logic [NI-1:0] r;
    for (int i = 0; i < NI; i++) begin
      bit a = 1, o = 0, any = 0;
      for (int g = 0; g < NG; g++) begin
        bit c = r_tbl[g][t[g*8 +: 8]][i];
        if (r_mask[g][i]) begin any = 1; a = a & c; o = o | c; end
      end
      r[i] = r_func[i] ? (a & any) : o;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [NI-1:0] exp);
    n_run++;
    if (item_out !== exp) begin
      n_fail++;
      $display("FAIL %s: item_out=%h expected=%h", req, item_out, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [1:0] g, input logic [7:0] a,
                    input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_grp = g; wr_addr = a; wr_lane = '0; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (s == 2'd0) r_tbl[g][a] = d;
    else if (s == 2'd1) r_mask[g] = d;
    else if (s == 2'd2) r_func = d;
  endtask

  task automatic apply(input logic [31:0] t, input string req);
    @(negedge clk); trig_in = t;
    @(negedge clk); check(req, model(t));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      r_mask[g] = '0;
      for (int a = 0; a < 256; a++) r_tbl[g][a] = '0;
    end
    r_func = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset clear", '0);
    trig_in = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R1 reset clear with input", '0);

    for (int g = 0; g < NG; g++)
      for (int a = 0; a < 256; a++)
        wr(2'd0, 2'(g), 8'(a), (32'(a) * 32'h9E37_79B1) ^ (32'(g) * 32'h7F4A_7C15) ^ {24'h0, 8'(a)});
    check("R1 masks clear after table load", '0);

    wr(2'd1, 2'd0, 8'd0, 32'h7FFF_0F0F);
    wr(2'd1, 2'd1, 8'd0, 32'h7F0F_33CC);
    wr(2'd1, 2'd2, 8'd0, 32'h70F0_5555);
    wr(2'd1, 2'd3, 8'd0, 32'h7F00_FFFF);
    wr(2'd2, 2'd0, 8'd0, 32'hA5C3_0F96);

    foreach (VEC[k]) apply(VEC[k], "R2 R4 R5 R8 vector walk");

    wr(2'd2, 2'd0, 8'd0, 32'hFFFF_FFFF);
    apply(32'hA55A_C33C, "R4 all AND");
    wr(2'd2, 2'd0, 8'd0, 32'h0000_0000);
    apply(32'hA55A_C33C, "R4 all OR");
    n_run++;
    if (item_out[31] !== 1'b0) begin
      n_fail++; $display("FAIL R3: item31=%b expected=0", item_out[31]);
    end

    wr(2'd1, 2'd1, 8'd0, 32'h0000_0001);
    wr(2'd1, 2'd2, 8'd0, 32'h0000_0000);
    wr(2'd1, 2'd3, 8'd0, 32'h0000_0000);
    wr(2'd1, 2'd0, 8'd0, 32'h0000_0001);
    wr(2'd0, 2'd0, 8'h11, 32'h0000_0001);
    wr(2'd0, 2'd1, 8'h22, 32'h0000_0000);
    wr(2'd2, 2'd0, 8'd0, 32'hFFFF_FFFF);
    apply(32'h0000_2211, "R3 masked group neutral for AND");
    wr(2'd1, 2'd1, 8'd0, 32'h0000_0000);
    apply(32'h0000_2211, "R3 masked-out zero leaves AND true");

    wr(2'd2, 2'd0, 8'd0, 32'h0000_0000);
    wr(2'd1, 2'd0, 8'd0, 32'hFFFF_FFFF);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); trig_in = 32'h0000_0011; wr_en = 1; wr_sel = 2'd3;
      wr_grp = 2'(s); wr_addr = 8'h11; wr_data = 32'hFFFF_FFFF;
      @(negedge clk); wr_en = 0;
      @(negedge clk); check("R6 select 3 ignored", model(32'h0000_0011));
    end

    @(negedge clk); trig_in = 32'h0000_0033;
    @(negedge clk); check("R7 before write", model(32'h0000_0033));
    wr_en = 1; wr_sel = 2'd0; wr_grp = 2'd0; wr_addr = 8'h33; wr_data = ~r_tbl[0][8'h33];
    @(negedge clk); wr_en = 0;
    check("R7 same edge keeps old", model(32'h0000_0033));
    r_tbl[0][8'h33] = wr_data;
    @(negedge clk); check("R7 new content next edge", model(32'h0000_0033));

    @(negedge clk); trig_in = 32'h0000_0044;
    check("R5 latency old value", model(32'h0000_0033));
    @(negedge clk); check("R5 latency new value", model(32'h0000_0044));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule